// File: doc/BRIEF.md
# Receive Packet FIFO with End-of-Packet Tagging

This block buffers received bytes between a serial-link frame receiver and a processor read port. Each stored byte carries one tag bit that marks it as the last byte of a packet. On the read side the block shows, as a level, whether the byte at the head of the queue closes a packet. A read made while the queue is empty returns zero and is reported by a one-cycle pulse. The receiver gives the block data bytes, end-of-packet tags, a pulse when it has seen a flag, and the high byte of the received checksum.

A one-cycle pulse marks each tagged byte that is written. The checksum high byte that comes with that byte is stored and held until the next tagged byte, exactly as it arrives. A second pulse marks the cycle in which the fill level first rises above a programmable threshold. A write attempted into a completely full queue raises an overflow pulse and closes a write gate. The gate is a two-state machine: in state GATE_OPEN, transition t_overrun (a write attempt at full depth) leads to GATE_BLOCKED. In GATE_BLOCKED, transition t_resync (the receiver's flag pulse) leads back to GATE_OPEN. While the gate is blocked, every incoming byte is discarded.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After reset, level is 0, head_last, empty_rd, eop_det, full_hit, ovfl and wr_blocked are 0, and crc_hi is 0x00.
- R2: Bytes are read out in the order they were accepted. The byte from a read with rd_req high at edge k appears on rd_data after edge k.
- R3: head_last is 1 exactly when the FIFO holds at least one byte and the byte at the head was written with wr_eop=1.
- R4: A read with level 0 gives rd_data=0x00 and a one-cycle empty_rd pulse after that edge. It does not move the read position, so the next byte written is the next byte read.
- R5: eop_det pulses for one cycle after each accepted write with wr_eop=1. It stays low for untagged writes and for discarded writes.
- R6: crc_hi takes crc_in unchanged at each accepted write with wr_eop=1. It holds its value at all other times.
- R7: full_hit pulses for one cycle after an edge at which level goes from at most full_thresh (7-bit, unsigned) to above it. It does not pulse while level stays above full_thresh.
- R8: A write attempt in GATE_OPEN with level equal to DEPTH (128) is discarded. It gives a one-cycle ovfl pulse and moves the gate to GATE_BLOCKED (wr_blocked=1). Fullness is judged before any read in the same cycle.
- R9: In GATE_BLOCKED, writes are discarded with no ovfl pulse. A flag_seen pulse returns the gate to GATE_OPEN after that edge. flag_seen has no effect in GATE_OPEN. If nothing has been read, the next write after reopening overflows again.
- R10: An accepted write together with an accepted read leaves level unchanged.
- R11: level always equals the number of bytes stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Receiver offers a byte this cycle |
| wr_data | input | 8 | Received byte |
| wr_eop | input | 1 | Offered byte closes a packet |
| flag_seen | input | 1 | Receiver detected a flag (pulse) |
| crc_in | input | 8 | Received checksum high byte, valid with a tagged byte |
| rd_req | input | 1 | Processor read request |
| full_thresh | input | 7 | Fill threshold for full_hit |
| rd_data | output | 8 | Byte returned by the last read |
| head_last | output | 1 | Head byte is the last byte of a packet |
| empty_rd | output | 1 | Pulse: a read found the FIFO empty |
| eop_det | output | 1 | Pulse: a tagged byte was stored |
| full_hit | output | 1 | Pulse: level crossed above full_thresh |
| ovfl | output | 1 | Pulse: write attempted at full depth |
| wr_blocked | output | 1 | Write gate is in GATE_BLOCKED |
| crc_hi | output | 8 | Captured checksum high byte |
| level | output | 8 | Number of stored bytes |

## Verification
Two functions can act in the same cycle. A write can arrive with a read, and an overflow attempt can arrive with a read of the full queue. The bench drives both. It writes while reading an empty queue, where the read must return zero while the byte is still stored. It writes and reads together on a non-empty queue, where the level must not change. It offers a byte to a full queue in the same cycle as a read, where the byte must be refused with an ovfl pulse while the read still pops the head. The scoreboard's own acceptance model judges every case and compares the popped bytes, level and pulses against it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic {
        GATE_OPEN    = 1'b0,
        GATE_BLOCKED = 1'b1
    } gate_state_t;
endpackage

// File: rtl/rxf_gate.sv
module rxf_gate
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic full,
    input  logic flag_seen,
    output logic wr_accept,
    output logic ovfl_hit,
    output logic blocked
);
    gate_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN:    if (wr_valid && full) state_d = GATE_BLOCKED;  // t_overrun
            GATE_BLOCKED: if (flag_seen)        state_d = GATE_OPEN;     // t_resync
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_accept = 1'b0;
        ovfl_hit  = 1'b0;
        blocked   = 1'b0;
        unique case (state_q)
            GATE_OPEN: begin
                wr_accept = wr_valid && !full;
                ovfl_hit  = wr_valid && full;
            end
            GATE_BLOCKED: blocked = 1'b1;
        endcase
    end
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
    parameter  int DEPTH = 128,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_accept,
    input  logic          rd_req,
    input  logic [AW-1:0] thresh,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          rd_accept,
    output logic          full_hit
);
    logic [CW-1:0] count_d;
    logic [CW-1:0] thr_w;

    assign thr_w     = {1'b0, thresh};
    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign rd_accept = rd_req && !empty;

    always_comb begin
        unique case ({wr_accept, rd_accept})
            2'b10:   count_d = count + 1'b1;
            2'b01:   count_d = count - 1'b1;
            default: count_d = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            full_hit <= 1'b0;
        end else begin
            count    <= count_d;
            full_hit <= (count <= thr_w) && (count_d > thr_w);
        end
    end
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter  int DEPTH = 128,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_tag,
    input  logic          rd_en,
    input  logic          rd_empty,
    output logic [DW-1:0] rd_data,
    output logic          head_tag
);
    // DEPTH must be a power of two: pointers wrap by overflow.
    logic [DW:0]   mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= {wr_tag, wr_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) wptr <= wptr + 1'b1;
            if (rd_en) begin
                rd_data <= mem[rptr][DW-1:0];
                rptr    <= rptr + 1'b1;
            end else if (rd_empty) begin
                rd_data <= '0;
            end
        end
    end

    assign head_tag = mem[rptr][DW];
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo #(
    parameter  int DEPTH = 128,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_eop,
    input  logic          flag_seen,
    input  logic [7:0]    crc_in,
    input  logic          rd_req,
    input  logic [AW-1:0] full_thresh,
    output logic [DW-1:0] rd_data,
    output logic          head_last,
    output logic          empty_rd,
    output logic          eop_det,
    output logic          full_hit,
    output logic          ovfl,
    output logic          wr_blocked,
    output logic [7:0]    crc_hi,
    output logic [CW-1:0] level
);
    logic wr_accept, ovfl_hit, full, empty, rd_accept, head_tag;

    rxf_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .full      (full),
        .flag_seen (flag_seen),
        .wr_accept (wr_accept),
        .ovfl_hit  (ovfl_hit),
        .blocked   (wr_blocked)
    );

    rxf_level #(.DEPTH(DEPTH)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .rd_req    (rd_req),
        .thresh    (full_thresh),
        .count     (level),
        .empty     (empty),
        .full      (full),
        .rd_accept (rd_accept),
        .full_hit  (full_hit)
    );

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_accept),
        .wr_data  (wr_data),
        .wr_tag   (wr_eop),
        .rd_en    (rd_accept),
        .rd_empty (rd_req && empty),
        .rd_data  (rd_data),
        .head_tag (head_tag)
    );

    assign head_last = !empty && head_tag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eop_det  <= 1'b0;
            empty_rd <= 1'b0;
            ovfl     <= 1'b0;
            crc_hi   <= '0;
        end else begin
            eop_det  <= wr_accept && wr_eop;
            empty_rd <= rd_req && empty;
            ovfl     <= ovfl_hit;
            if (wr_accept && wr_eop) crc_hi <= crc_in;
        end
    end
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk #(
    parameter  int DEPTH = 128,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_eop,
    input logic          flag_seen,
    input logic [7:0]    crc_in,
    input logic          rd_req,
    input logic [AW-1:0] full_thresh,
    input logic [DW-1:0] rd_data,
    input logic          head_last,
    input logic          empty_rd,
    input logic          eop_det,
    input logic          full_hit,
    input logic          ovfl,
    input logic          wr_blocked,
    input logic [7:0]    crc_hi,
    input logic [CW-1:0] level
);
    assert_head_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        head_last |-> (level != '0));

    assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty_rd |-> (rd_data == '0));

    assert_eop_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_eop && !wr_blocked && level != CW'(DEPTH)) |=> eop_det);

    assert_crc_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_eop && !wr_blocked && level != CW'(DEPTH)) |=> (crc_hi == $past(crc_in)));

    assert_crossing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_hit && $stable(full_thresh)) |-> (level > {1'b0, full_thresh}));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_blocked && level == CW'(DEPTH)) |=> (ovfl && wr_blocked));

    assert_stay_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_blocked && !flag_seen) |=> wr_blocked);

    assert_blocked_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_blocked && wr_valid && !rd_req) |=> ($stable(level) && !ovfl));

    assert_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rd_req && !wr_blocked && level != '0 && level != CW'(DEPTH)) |=> $stable(level));

    assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_eop      (wr_eop),
    .flag_seen   (flag_seen),
    .crc_in      (crc_in),
    .rd_req      (rd_req),
    .full_thresh (full_thresh),
    .rd_data     (rd_data),
    .head_last   (head_last),
    .empty_rd    (empty_rd),
    .eop_det     (eop_det),
    .full_hit    (full_hit),
    .ovfl        (ovfl),
    .wr_blocked  (wr_blocked),
    .crc_hi      (crc_hi),
    .level       (level)
);

// File: tb/tb_rx_pkt_fifo.sv
`timescale 1ns/1ps
module tb_rx_pkt_fifo;
    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, wr_eop = 1'b0, flag_seen = 1'b0, rd_req = 1'b0;
    logic [7:0] wr_data = '0, crc_in = '0;
    logic [6:0] full_thresh = 7'd100;
    logic [7:0] rd_data, crc_hi, level;
    logic       head_last, empty_rd, eop_det, full_hit, ovfl, wr_blocked;

    int checks = 0;
    int errors = 0;

    logic [8:0] sb[$];       // {eop, data}: scoreboard of accepted bytes
    logic       mlock = 1'b0;
    logic [7:0] mcrc = '0;
    logic [8:0] mon_exp;
    logic       mon_emp;

    always #4 clk = ~clk;    // 125 MHz

    rx_pkt_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_eop(wr_eop), .flag_seen(flag_seen), .crc_in(crc_in), .rd_req(rd_req),
        .full_thresh(full_thresh), .rd_data(rd_data), .head_last(head_last),
        .empty_rd(empty_rd), .eop_det(eop_det), .full_hit(full_hit), .ovfl(ovfl),
        .wr_blocked(wr_blocked), .crc_hi(crc_hi), .level(level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard when a read is sampled and compares the result.
    always @(posedge clk) begin
        if (rst_n && rd_req) begin
            if (sb.size() > 0) begin
                mon_exp = sb.pop_front();
                mon_emp = 1'b0;
            end else begin
                mon_exp = '0;
                mon_emp = 1'b1;
            end
            #2;
            chk(rd_data == mon_exp[7:0], mon_emp ? "R4 empty read data" : "R2 read order",
                rd_data, mon_exp[7:0]);
            chk(empty_rd == mon_emp, "R4 empty_rd pulse", empty_rd, mon_emp);
        end
    end

    // Driver: one cycle of stimulus, own acceptance model, checks after the edge.
    task automatic step(input logic wv, input logic [7:0] wd, input logic we,
                        input logic rd, input logic fl, input logic [7:0] crc);
        int  pre;
        bit  acc, ov;
        wr_valid = wv; wr_data = wd; wr_eop = we; rd_req = rd;
        flag_seen = fl; crc_in = crc;
        pre = sb.size();
        acc = wv && !mlock && pre < DEPTH;
        ov  = wv && !mlock && pre == DEPTH;
        @(posedge clk); #1;
        if (acc) sb.push_back({we, wd});
        if (ov) mlock = 1'b1;
        else if (mlock && fl) mlock = 1'b0;
        if (acc && we) mcrc = crc;
        chk(level == sb.size(), "R11/R10 level", level, sb.size());
        chk(eop_det == (acc && we), "R5 eop_det", eop_det, acc && we);
        chk(crc_hi == mcrc, "R6 crc_hi", crc_hi, mcrc);
        chk(ovfl == ov, "R8 ovfl", ovfl, ov);
        chk(wr_blocked == mlock, "R9 wr_blocked", wr_blocked, mlock);
        chk(full_hit == (pre <= full_thresh && sb.size() > full_thresh),
            "R7 full_hit", full_hit, pre <= full_thresh && sb.size() > full_thresh);
        chk(head_last == (sb.size() > 0 && sb[0][8]), "R3 head_last", head_last,
            sb.size() > 0 && sb[0][8]);
        wr_valid = 0; rd_req = 0; flag_seen = 0; wr_eop = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(level == 0, "R1 level", level, 0);
        chk(!head_last && !empty_rd && !eop_det && !full_hit && !ovfl && !wr_blocked,
            "R1 flags", {head_last, empty_rd, eop_det, full_hit, ovfl, wr_blocked}, 0);
        chk(crc_hi == 0, "R1 crc_hi", crc_hi, 0);
        rst_n = 1'b1;

        // R2 R3 R5 R6: a three-byte packet
        step(1, 8'hAA, 0, 0, 0, 8'h11);
        step(1, 8'hBB, 0, 0, 0, 8'h22);
        step(1, 8'hCC, 1, 0, 0, 8'h5A);
        step(1, 8'hDD, 0, 0, 0, 8'h77);   // crc_hi must hold 0x5A
        repeat (4) step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);           // R4 empty read
        // R4 empty read together with a write: byte kept, next read returns it
        step(1, 8'h31, 1, 1, 0, 8'hC3);
        // R10 write + read on non-empty FIFO
        step(1, 8'h32, 0, 1, 0, 0);
        step(1, 8'h33, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        // R9 flag in open state has no effect
        step(0, 0, 0, 0, 1, 0);

        // R7 fill to DEPTH with threshold 100
        for (int i = 0; i < DEPTH; i++)
            step(1, 8'(i), (i % 32) == 31, 0, 0, 8'(255 - i));
        // R8 overflow attempt at full depth while reading
        step(1, 8'hEE, 0, 1, 0, 0);
        // R9 blocked: writes discarded
        repeat (3) step(1, 8'hEF, 1, 0, 0, 8'h99);
        step(0, 0, 0, 0, 1, 0);           // R9 resync on flag
        step(1, 8'hF0, 0, 0, 0, 0);       // refills to 128
        step(1, 8'hF1, 0, 0, 0, 0);       // R9 overflow recurs
        step(0, 0, 0, 0, 1, 0);
        // drain and verify order
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 1, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule